// File: doc/BRIEF.md
# I2C Byte Master with Arbitration Back-off

This block is a byte-oriented master for a two-wire I2C bus. It is controlled by a few level and pulse inputs. Software loads a two-byte buffer. Byte 0 carries the slave address, or the first address byte in 10-bit mode, and later the outgoing data. A level input `bus_en` asks for ownership of the bus: its rising request produces a START, and its removal produces a STOP once the current byte is done. A request for a repeated START is latched in a flag that clears itself in hardware. After every byte the engine parks with SCL held low. It raises a one-cycle `done` pulse and waits for the next command.

Both bus wires are open-drain. The outputs are pull-down enables, so 1 pulls the wire low and 0 releases it. While shifting out a bit it means to leave high, the master compares its intent with the sampled SDA. If the wire reads low, it concludes that another master has won. It then lets go of both wires at once, drops `busy` and raises a sticky `arb_lost` flag. It starts again only after `bus_en` has been withdrawn and asserted anew. The bit rate is fixed by a quarter-bit divider parameter. Slaves cannot stretch the clock.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset, and whenever `busy` is low, both `scl_oe` and `sda_oe` are 0. `done`, `rs_req` and `arb_lost` are 0 after reset.
- R2: When `bus_en` is 1 while idle and armed, the master sets `busy` and makes SDA fall while SCL is high (START). It then shifts out buffer byte 0 MSB first. Bit 0 of that byte is the read/write bit: 1 means read.
- R3: When `addr10` is 1 at START, the first byte after the START is buffer byte 0 and the next byte sent (on `next_byte`) is buffer byte 1. The direction is still taken from bit 0 of byte 0.
- R4: SDA changes while SCL is released only during START, repeated START and STOP sequences.
- R5: After each transmitted byte, SDA is released for the ninth clock. The level sampled there is reported in `nack` (0 = acknowledged) when `done` pulses.
- R6: In a read transfer, each data byte is taken MSB first into `rx_data`. In the ninth clock the master pulls SDA low (ACK) unless `rx_nack` is 1.
- R7: `done` is a single-cycle pulse at the end of every byte, address bytes included.
- R8: `rs_set` sets `rs_req` only while `busy` is 1. The pending request produces a repeated START (SDA falls while SCL is high, with no STOP before it). `busy` stays 1 throughout, and `rs_req` clears itself once the repeated START is on the bus. The address byte(s) are then sent again.
- R9: When `bus_en` is 0 while parked after a byte, the master produces a STOP (SDA rises while SCL is high). `busy` clears only once the STOP is complete, with both wires released.
- R10: If SDA reads low during a data or address bit the master left released, it releases both wires, clears `busy`, sets `arb_lost` and clears any pending `rs_req`. It does not start again while `bus_en` stays 1. `arb_lost` clears at the next START.
- R11: When parked, withdrawing `bus_en` takes priority over a repeated-start request, which takes priority over `next_byte`. An `rs_set` pulse in the same cycle as `next_byte` counts as a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus-master control level: set for START, clear for STOP |
| rs_set | input | 1 | Pulse requesting a repeated START |
| addr10 | input | 1 | 10-bit addressing when 1 at START |
| next_byte | input | 1 | Pulse: run the next byte while parked |
| rx_nack | input | 1 | Answer NACK instead of ACK to received bytes |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 1 | Buffer byte select (0 or 1) |
| wr_data | input | 8 | Buffer write data |
| sda_in | input | 1 | Sampled SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| rs_req | output | 1 | Repeated-start request pending |
| done | output | 1 | One-cycle pulse at each byte end |
| nack | output | 1 | Acknowledge level seen after the last sent byte |
| arb_lost | output | 1 | Arbitration was lost (sticky until next START) |
| rx_data | output | 8 | Last received byte |

## Verification
The block can see several commands in the same cycle while it is parked: a withdrawn `bus_en` together with an `rs_set` pulse, and an `rs_set` pulse together with `next_byte`. The bench raises each pair on one clock edge. A bus model counts STARTs and STOPs and logs every byte on the wires, and the bench uses it to decide which command won. In the first case it expects exactly one more STOP, no extra START and a cleared request. In the second it expects one more START, with the logged byte equal to the address in buffer byte 0.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_HOLD, S_RSTART, S_STOP
  } st_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(parameter int QDIV = 4) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(QDIV - 1));
      cnt  <= (cnt == CW'(QDIV - 1)) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_buf.sv
module i2cm_buf #(parameter int BW = 8) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_idx,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] b0,
  output logic [BW-1:0] b1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      b0 <= '0;
      b1 <= '0;
    end else if (wr_en) begin
      if (wr_idx) b1 <= wr_data;
      else        b0 <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master import i2cm_pkg::*; #(
  parameter int QDIV = 4,
  parameter int BW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          rs_set,
  input  logic          addr10,
  input  logic          next_byte,
  input  logic          rx_nack,
  input  logic          wr_en,
  input  logic          wr_idx,
  input  logic [BW-1:0] wr_data,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          rs_req,
  output logic          done,
  output logic          nack,
  output logic          arb_lost,
  output logic [BW-1:0] rx_data
);
  localparam int NW = $clog2(BW + 1);

  logic          tick;
  logic [BW-1:0] b0, b1;
  st_t           st;
  logic [1:0]    ph;
  logic [NW-1:0] bitn;
  logic [BW-1:0] sh;
  logic          acnt, dir_rd, is_tx, armed;
  logic          rs_any;

  i2cm_tick #(.QDIV(QDIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));
  i2cm_buf  #(.BW(BW)) u_buf (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
                              .wr_data(wr_data), .b0(b0), .b1(b1));

  assign rs_any = rs_req | (rs_set & busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0;
      acnt <= 1'b0; dir_rd <= 1'b0; is_tx <= 1'b1; armed <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; busy <= 1'b0; rs_req <= 1'b0;
      done <= 1'b0; nack <= 1'b0; arb_lost <= 1'b0; rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (!bus_en) armed <= 1'b1;
      if (rs_set && busy) rs_req <= 1'b1;
      case (st)
        S_IDLE: begin
          if (bus_en && armed) begin
            st <= S_START; ph <= '0; busy <= 1'b1; arb_lost <= 1'b0;
          end
        end
        S_START: if (tick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd0) sda_oe <= 1'b1;
          if (ph == 2'd1) begin
            scl_oe <= 1'b1; st <= S_BIT; ph <= '0; bitn <= '0;
            sh <= b0; acnt <= addr10; dir_rd <= b0[0]; is_tx <= 1'b1;
          end
        end
        S_BIT: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= (bitn == NW'(BW)) ? (!is_tx && !rx_nack)
                                              : (is_tx && !sh[BW-1]);
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (bitn != NW'(BW) && is_tx && !sda_oe && !sda_in) begin
                st <= S_IDLE; busy <= 1'b0; arb_lost <= 1'b1; armed <= 1'b0;
                rs_req <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
              end else if (bitn != NW'(BW)) begin
                sh <= {sh[BW-2:0], sda_in};
              end else if (is_tx) begin
                nack <= sda_in;
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn == NW'(BW)) begin
                done <= 1'b1; st <= S_HOLD;
                if (!is_tx) rx_data <= sh;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          endcase
        end
        S_HOLD: begin
          ph <= '0;
          if (!bus_en)     st <= S_STOP;
          else if (rs_any) st <= S_RSTART;
          else if (next_byte) begin
            st <= S_BIT; bitn <= '0;
            if (acnt) begin
              sh <= b1; acnt <= 1'b0; is_tx <= 1'b1;
            end else begin
              sh <= b0; is_tx <= !dir_rd;
            end
          end
        end
        S_RSTART: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1; rs_req <= 1'b0; st <= S_BIT; ph <= '0; bitn <= '0;
              sh <= b0; acnt <= addr10; dir_rd <= b0[0]; is_tx <= 1'b1;
            end
          endcase
        end
        S_STOP: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              busy <= 1'b0; rs_req <= 1'b0; st <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk import i2cm_pkg::*; (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic rs_req,
  input logic done,
  input logic arb_lost,
  input st_t  st
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));
  a_r2_start_free: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!scl_oe && !sda_oe));
  a_r4_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(st) == S_START || $past(st) == S_RSTART || $past(st) == S_STOP));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_rs_only_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_req) |-> busy);
  a_r8_rs_clear_on_bus: assert property (@(posedge clk) disable iff (rst)
    ($fell(rs_req) && busy) |-> (scl_oe && sda_oe));
  a_r9_busy_fall_released: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!scl_oe && !sda_oe));
  a_r10_arb_backoff: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!busy && !scl_oe && !sda_oe && !rs_req));
endmodule

bind i2c_arb_master i2cm_chk u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
  .rs_req(rs_req), .done(done), .arb_lost(arb_lost), .st(st)
);

// File: tb/tb_i2c_arb_master.sv
module tb_i2c_arb_master;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 0, rs_set = 0, addr10 = 0, next_byte = 0, rx_nack = 0;
  logic wr_en = 0, wr_idx = 0;
  logic [7:0] wr_data = '0;
  logic sda_in, scl_oe, sda_oe, busy, rs_req, done, nack, arb_lost;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  // bus model state
  logic s_pull = 0, m2_pull = 0, m2_arm = 0, s_nack = 0;
  logic scl_l, sda_l, scl_p = 1, sda_p = 1, first = 0, rd_act = 0, ack_seen = 0;
  logic [7:0] sbyte = '0, rd_data = '0;
  logic [7:0] lg [0:63];
  int bcnt = 0, lg_n = 0, starts = 0, stops = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign scl_l  = ~scl_oe;
  assign sda_l  = ~(sda_oe | s_pull | m2_pull);
  assign sda_in = sda_l;

  i2c_arb_master dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .rs_set(rs_set), .addr10(addr10),
    .next_byte(next_byte), .rx_nack(rx_nack), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .rs_req(rs_req), .done(done), .nack(nack),
    .arb_lost(arb_lost), .rx_data(rx_data)
  );

  always @(negedge clk) begin
    if (scl_l && scl_p && sda_p && !sda_l) begin
      starts++; bcnt = 0; first = 1; rd_act = 0; s_pull = 0;
    end else if (scl_l && scl_p && !sda_p && sda_l) begin
      stops++; rd_act = 0;
    end else if (scl_l && !scl_p) begin
      if (bcnt < 8) sbyte = {sbyte[6:0], sda_l};
      else ack_seen = sda_l;
      bcnt++;
    end else if (!scl_l && scl_p) begin
      if (bcnt == 0 && m2_arm) begin m2_pull = 1; m2_arm = 0; end
      if (bcnt == 8) s_pull = rd_act ? 1'b0 : ~s_nack;
      else if (bcnt == 9) begin
        lg[lg_n[5:0]] = sbyte; lg_n++; bcnt = 0;
        if (rd_act && ack_seen) rd_act = 0;
        else if (first && sbyte[0]) rd_act = 1;
        first = 0;
        s_pull = rd_act ? ~rd_data[7] : 1'b0;
      end else if (rd_act && bcnt >= 1 && bcnt <= 7) s_pull = ~rd_data[7-bcnt];
    end
    scl_p = scl_l; sda_p = sda_l;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wbuf(input logic idx, input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_next();
    @(negedge clk); next_byte = 1; @(negedge clk); next_byte = 0;
    wait_done();
  endtask

  task automatic stop_bus();
    @(negedge clk); bus_en = 0;
    while (busy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] addr7(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int st0, sp0, n;
    logic [7:0] a, d;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk); rst = 0; @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0); chk("R1 rs_req", rs_req, 0); chk("R1 arb_lost", arb_lost, 0);

    // R8: request while idle is ignored
    @(negedge clk); rs_set = 1; @(negedge clk); rs_set = 0; @(negedge clk);
    chk("R8 idle rs ignored", rs_req, 0);

    // R2/R5: 7-bit write with ACK then NACK
    a = addr7(7'h2B, 0); wbuf(0, a);
    st0 = starts; bus_en = 1; wait_done();
    chk("R2 start seen", starts, st0 + 1); chk("R2 addr byte", lg[lg_n-1], a);
    chk("R2 busy", busy, 1); chk("R5 ack", nack, 0);
    wbuf(0, 8'h5C); pulse_next(); chk("R2 data byte", lg[lg_n-1], 8'h5C);
    s_nack = 1; wbuf(0, 8'hE1); pulse_next(); chk("R5 nack", nack, 1); s_nack = 0;
    sp0 = stops; stop_bus();
    chk("R9 stop seen", stops, sp0 + 1); chk("R9 busy low", busy, 0);
    chk("R1 lines released", {scl_oe, sda_oe}, 0);

    // R6: read two bytes, ACK then NACK
    rd_data = 8'hA7; wbuf(0, addr7(7'h51, 1)); bus_en = 1; wait_done();
    rx_nack = 0; pulse_next();
    chk("R6 rx byte", rx_data, 8'hA7); chk("R6 master ack", ack_seen, 0);
    rx_nack = 1; pulse_next();
    chk("R6 rx byte2", rx_data, 8'hA7); chk("R6 master nack", ack_seen, 1);
    rx_nack = 0; stop_bus();

    // R3: 10-bit address
    addr10 = 1; wbuf(0, 8'hF4); wbuf(1, 8'h3D); bus_en = 1; wait_done();
    chk("R3 first addr byte", lg[lg_n-1], 8'hF4);
    pulse_next(); chk("R3 second addr byte", lg[lg_n-1], 8'h3D);
    wbuf(0, 8'h99); pulse_next(); chk("R3 data after addr", lg[lg_n-1], 8'h99);
    stop_bus(); addr10 = 0;

    // R8: repeated start keeps busy, clears itself
    a = addr7(7'h12, 0); wbuf(0, a); bus_en = 1; wait_done();
    st0 = starts; sp0 = stops;
    @(negedge clk); rs_set = 1; @(negedge clk); rs_set = 0;
    chk("R8 rs pending", rs_req | (starts != st0), 1);
    n = 0;
    while (rs_req) begin @(negedge clk); if (!busy) n++; end
    chk("R8 busy held", n, 0);
    wait_done();
    chk("R8 rs cleared", rs_req, 0); chk("R8 restart", starts, st0 + 1);
    chk("R8 no stop", stops, sp0); chk("R8 addr resent", lg[lg_n-1], a);

    // R11: rs_set together with next_byte -> repeated start wins
    st0 = starts;
    @(negedge clk); rs_set = 1; next_byte = 1; @(negedge clk); rs_set = 0; next_byte = 0;
    wait_done();
    chk("R11 rs over next", starts, st0 + 1); chk("R11 addr byte", lg[lg_n-1], a);

    // R11: bus_en withdrawn together with rs_set -> STOP wins
    st0 = starts; sp0 = stops;
    @(negedge clk); bus_en = 0; rs_set = 1; @(negedge clk); rs_set = 0;
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R11 stop wins", stops, sp0 + 1); chk("R11 no restart", starts, st0);
    chk("R11 rs dropped", rs_req, 0);

    // R10: arbitration loss on a released bit
    wbuf(0, 8'hA0); m2_arm = 1; bus_en = 1;
    @(negedge clk); while (!arb_lost) @(negedge clk);
    @(negedge clk);
    chk("R10 busy", busy, 0); chk("R10 lines", {scl_oe, sda_oe}, 0);
    chk("R10 flag", arb_lost, 1);
    m2_pull = 0; repeat (100) @(negedge clk);
    chk("R10 no retry", busy, 0);
    bus_en = 0; repeat (4) @(negedge clk);
    a = addr7(7'h33, 0); wbuf(0, a); bus_en = 1; wait_done();
    chk("R10 flag cleared", arb_lost, 0); chk("R10 retry addr", lg[lg_n-1], a);
    stop_bus();

    // random 7-bit writes
    for (int t = 0; t < 6; t++) begin
      a = addr7(7'($urandom), 0); wbuf(0, a); bus_en = 1; wait_done();
      chk("R2 rnd addr", lg[lg_n-1], a);
      for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
        d = 8'($urandom); wbuf(0, d); pulse_next();
        chk("R2 rnd data", lg[lg_n-1], d);
        chk("R5 rnd ack", nack, 0);
      end
      stop_bus();
      chk("R9 rnd idle", busy, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule